// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

This block holds a small bank of binary lock flags that two independent agents, a left port and a right port, use to agree on who may use a shared resource. Each flag can be owned by at most one side at a time. An agent claims a flag by writing 0 to it and then reads the flag back to learn whether the claim succeeded. It gives the flag up by writing 1. The block only records ownership. It does not guard any resource itself.

Each side has its own request latch for every flag. A claim from the side that does not hold the flag is kept as a pending request. When the holder lets go, the flag passes straight to that waiting side and never becomes free in between. The whole unit runs on one clock, and both ports may access it in the same cycle. When both sides claim the same free flag in one cycle, the left port wins.

Reads return the flag as it looks from the reading side, spread across the whole read bus. The value is taken once, when a read begins, and stays frozen until the read ends.

Top module: `twoport_sema`

## Requirements
- R1: A synchronous reset sets every request latch to the released state. After reset every flag is free, and both read buses show all ones.
- R2: The flag is selected by the lowest three bits of the port address, flags 0 to 7. All higher address bits are ignored.
- R3: A write takes place only in a cycle where the port's select and write enable are both high. Only bit 0 of the write data counts: 0 is a claim and 1 is a release. A cycle with select low changes no flag.
- R4: A claim on a free flag gives ownership to the claiming side. That side then reads 0x00 and the other side reads 0xFF.
- R5: A claim from the side that does not own a flag does not change ownership. That side keeps reading 0xFF while its request stays pending.
- R6: When the owner releases a flag that has a pending request from the other side, ownership moves to that side directly. The other side then reads 0x00 and the former owner reads 0xFF.
- R7: A flag becomes free, reading 0xFF on both sides, only when neither side's latch holds a claim. A side that is not the owner can withdraw a pending claim by writing 1.
- R8: A read replicates the flag's view onto all eight data bits, so the value read is always 0x00 or 0xFF.
- R9: A read is captured in the cycle in which select and output enable first become high together. The captured value is the flag state before that cycle's writes, and it appears on the bus after that clock edge. It is then held while both signals stay high, whatever either side writes. In a cycle where they are not both high, the bus returns to 0xFF on the next edge.
- R10: When both sides claim the same free flag in one cycle, the left side becomes owner and the right side's claim stays pending. Both sides never read 0x00 for the same flag.
- R11: A claim stays in force for as long as its side does not release it. There is no timeout and no self-clearing.
- R12: The flags are independent. A write to one flag leaves every other flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| l_sel | input | 1 | Left semaphore select |
| l_we | input | 1 | Left write enable |
| l_oe | input | 1 | Left output enable (read) |
| l_addr | input | 12 | Left address, low three bits select the flag |
| l_wdata | input | 8 | Left write data, bit 0 used |
| l_rdata | output | 8 | Left read data |
| r_sel | input | 1 | Right semaphore select |
| r_we | input | 1 | Right write enable |
| r_oe | input | 1 | Right output enable (read) |
| r_addr | input | 12 | Right address, low three bits select the flag |
| r_wdata | input | 8 | Right write data, bit 0 used |
| r_rdata | output | 8 | Right read data |

## Verification
Two events can fall in the same cycle. The first is a claim from each side on the same free flag. The second is a release by the owner while the other side claims, or while the other side holds a read open. The bench provokes the first by driving both write ports to one flag on one edge. It judges the outcome by later reads: the left side must see 0x00, the right side 0xFF, and the right side must take over as soon as the left side releases. The bench provokes the second by keeping one side's read open across a release by the other side. The frozen value must stay on the bus until the read ends, and the new owner's view must appear on the next fresh read.

// File: rtl/twp_sema_pkg.sv
package twp_sema_pkg;

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } own_e;

    // State of one flag: a request latch per side (0 = claim) and the current holder
    typedef struct packed {
        logic l_lat;
        logic r_lat;
        own_e owner;
    } flag_st_t;

    // State of one read port
    typedef struct packed {
        logic       act;
        logic [7:0] data;
    } rd_st_t;

endpackage

// File: rtl/sema_wr_decode.sv
module sema_wr_decode #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic                 sel,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [NUM_FLAGS-1:0] hit,
    output logic                 wr_bit
);
    logic [IDX_W-1:0] idx;
    logic             unused_bits;

    assign idx         = addr[IDX_W-1:0];
    assign wr_bit      = wdata[0];
    assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_hit
        assign hit[g] = sel && we && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/sema_flag_cell.sv
module sema_flag_cell
    import twp_sema_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic l_hit,
    input  logic l_val,
    input  logic r_hit,
    input  logic r_val,
    output own_e owner
);
    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (l_hit) st_d.l_lat = l_val;
        if (r_hit) st_d.r_lat = r_val;
        unique case (st_q.owner)
            OWN_LEFT: begin
                if (!st_d.l_lat)      st_d.owner = OWN_LEFT;
                else if (!st_d.r_lat) st_d.owner = OWN_RIGHT;
                else                  st_d.owner = OWN_NONE;
            end
            OWN_RIGHT: begin
                if (!st_d.r_lat)      st_d.owner = OWN_RIGHT;
                else if (!st_d.l_lat) st_d.owner = OWN_LEFT;
                else                  st_d.owner = OWN_NONE;
            end
            default: begin
                // free flag: left has priority on a same-cycle claim
                if (!st_d.l_lat)      st_d.owner = OWN_LEFT;
                else if (!st_d.r_lat) st_d.owner = OWN_RIGHT;
                else                  st_d.owner = OWN_NONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.l_lat <= 1'b1;
            st_q.r_lat <= 1'b1;
            st_q.owner <= OWN_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign owner = st_q.owner;
endmodule

// File: rtl/sema_read_port.sv
module sema_read_port
    import twp_sema_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 12,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel,
    input  logic                 oe,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [NUM_FLAGS-1:0] mine,
    output logic [7:0]           rdata
);
    rd_st_t           rd_d, rd_q;
    logic [IDX_W-1:0] idx;
    logic             unused_hi;

    assign idx       = addr[IDX_W-1:0];
    assign unused_hi = ^addr[ADDR_W-1:IDX_W];

    always_comb begin
        rd_d     = rd_q;
        rd_d.act = sel && oe;
        if (sel && oe) begin
            if (!rd_q.act) rd_d.data = {8{~mine[idx]}};
        end else begin
            rd_d.data = 8'hFF;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q.act  <= 1'b0;
            rd_q.data <= 8'hFF;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdata = rd_q.data;
endmodule

// File: rtl/twoport_sema.sv
module twoport_sema
    import twp_sema_pkg::*;
#(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sel,
    input  logic              l_we,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [7:0]        l_rdata,
    input  logic              r_sel,
    input  logic              r_we,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [7:0]        r_rdata
);
    logic [NUM_FLAGS-1:0]   l_hit, r_hit;
    logic                   l_bit, r_bit;
    logic [NUM_FLAGS-1:0]   l_mine, r_mine;
    logic [2*NUM_FLAGS-1:0] own_flat;

    sema_wr_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ldec (
        .sel(l_sel), .we(l_we), .addr(l_addr), .wdata(l_wdata), .hit(l_hit), .wr_bit(l_bit)
    );
    sema_wr_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rdec (
        .sel(r_sel), .we(r_we), .addr(r_addr), .wdata(r_wdata), .hit(r_hit), .wr_bit(r_bit)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        own_e own;
        sema_flag_cell u_cell (
            .clk(clk), .rst(rst),
            .l_hit(l_hit[g]), .l_val(l_bit),
            .r_hit(r_hit[g]), .r_val(r_bit),
            .owner(own)
        );
        assign l_mine[g]            = (own == OWN_LEFT);
        assign r_mine[g]            = (own == OWN_RIGHT);
        assign own_flat[2*g +: 2]   = own;
    end

    sema_read_port #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_lrd (
        .clk(clk), .rst(rst), .sel(l_sel), .oe(l_oe), .addr(l_addr), .mine(l_mine), .rdata(l_rdata)
    );
    sema_read_port #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_rrd (
        .clk(clk), .rst(rst), .sel(r_sel), .oe(r_oe), .addr(r_addr), .mine(r_mine), .rdata(r_rdata)
    );
endmodule

// File: rtl/twoport_sema_chk.sv
module twoport_sema_chk #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 12,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   l_sel,
    input logic                   l_oe,
    input logic [ADDR_W-1:0]      l_addr,
    input logic [7:0]             l_rdata,
    input logic                   r_sel,
    input logic                   r_oe,
    input logic [ADDR_W-1:0]      r_addr,
    input logic [7:0]             r_rdata,
    input logic [2*NUM_FLAGS-1:0] own_flat
);
    logic l_act, r_act, l_prev_q, r_prev_q;
    logic unused_hi;

    assign l_act     = l_sel && l_oe;
    assign r_act     = r_sel && r_oe;
    assign unused_hi = ^{l_addr[ADDR_W-1:IDX_W], r_addr[ADDR_W-1:IDX_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            l_prev_q <= 1'b0;
            r_prev_q <= 1'b0;
        end else begin
            l_prev_q <= l_act;
            r_prev_q <= r_act;
        end
    end

    // R1
    reset_free_chk: assert property (@(posedge clk) rst |=> (l_rdata == 8'hFF && r_rdata == 8'hFF));

    // R8
    always @(negedge clk) begin
        if (!rst) begin
            full_spread_chk: assert ((l_rdata == 8'h00 || l_rdata == 8'hFF) &&
                                     (r_rdata == 8'h00 || r_rdata == 8'hFF));
        end
    end

    // R9
    l_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (l_act && l_prev_q) |=> $stable(l_rdata));

    // R9
    r_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (r_act && r_prev_q) |=> $stable(r_rdata));

    // R9
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (!l_act && !r_act) |=> (l_rdata == 8'hFF && r_rdata == 8'hFF));

    // R10
    no_double_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (l_act && !l_prev_q && r_act && !r_prev_q &&
         l_addr[IDX_W-1:0] == r_addr[IDX_W-1:0]) |=> !(l_rdata == 8'h00 && r_rdata == 8'h00));

    // R3
    no_select_no_change_chk: assert property (@(posedge clk) disable iff (rst)
        (!l_sel && !r_sel) |=> $stable(own_flat));
endmodule

bind twoport_sema twoport_sema_chk #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst),
    .l_sel(l_sel), .l_oe(l_oe), .l_addr(l_addr), .l_rdata(l_rdata),
    .r_sel(r_sel), .r_oe(r_oe), .r_addr(r_addr), .r_rdata(r_rdata),
    .own_flat(own_flat)
);

// File: tb/twoport_sema_test.sv
`timescale 1ns/1ps
module twoport_sema_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic l_sel = 0, l_we = 0, l_oe = 0, r_sel = 0, r_we = 0, r_oe = 0;
    logic [11:0] l_addr = '0, r_addr = '0;
    logic [7:0]  l_wdata = '0, r_wdata = '0;
    logic [7:0]  l_rdata, r_rdata;

    int errors = 0, checks = 0, junk = 1;
    bit done = 0;

    // behavioural reference: 0 free, 1 left, 2 right
    int m_own[8];
    bit m_l[8], m_r[8];
    logic [7:0] m_rl = 8'hFF, m_rr = 8'hFF;
    bit m_la = 0, m_ra = 0;

    always #2.5 clk = ~clk;

    twoport_sema uut (
        .clk(clk), .rst(rst),
        .l_sel(l_sel), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] view(bit left, int i);
        if (left) return (m_own[i] == 1) ? 8'h00 : 8'hFF;
        return (m_own[i] == 2) ? 8'h00 : 8'hFF;
    endfunction

    task automatic model_step();
        int li = int'(l_addr[2:0]);
        int ri = int'(r_addr[2:0]);
        if (rst) begin
            for (int i = 0; i < 8; i++) begin m_own[i] = 0; m_l[i] = 1; m_r[i] = 1; end
            m_rl = 8'hFF; m_rr = 8'hFF; m_la = 0; m_ra = 0;
            return;
        end
        if (l_sel && l_oe) begin if (!m_la) m_rl = view(1, li); end else m_rl = 8'hFF;
        if (r_sel && r_oe) begin if (!m_ra) m_rr = view(0, ri); end else m_rr = 8'hFF;
        m_la = l_sel && l_oe;
        m_ra = r_sel && r_oe;
        if (l_sel && l_we) m_l[li] = l_wdata[0];
        if (r_sel && r_we) m_r[ri] = r_wdata[0];
        for (int i = 0; i < 8; i++) begin
            if (m_own[i] == 2) m_own[i] = !m_r[i] ? 2 : (!m_l[i] ? 1 : 0);
            else               m_own[i] = !m_l[i] ? 1 : (!m_r[i] ? 2 : 0);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        model_step();
        chk("R9 model left", l_rdata, m_rl);
        chk("R9 model right", r_rdata, m_rr);
        @(negedge clk);
    endtask

    task automatic idle();
        l_sel = 0; l_we = 0; l_oe = 0; r_sel = 0; r_we = 0; r_oe = 0;
    endtask

    function automatic logic [11:0] mk_addr(int i);
        junk = junk * 5 + 3;
        return {9'(junk), 3'(i)};
    endfunction

    task automatic wr(bit left, int i, logic [7:0] d);
        if (left) begin l_sel = 1; l_we = 1; l_addr = mk_addr(i); l_wdata = d; end
        else      begin r_sel = 1; r_we = 1; r_addr = mk_addr(i); r_wdata = d; end
        tick();
        idle();
    endtask

    task automatic rd_both(int i, logic [7:0] el, logic [7:0] er, string tag);
        l_sel = 1; l_oe = 1; l_addr = mk_addr(i);
        r_sel = 1; r_oe = 1; r_addr = mk_addr(i);
        tick();
        chk({tag, " left"}, l_rdata, el);
        chk({tag, " right"}, r_rdata, er);
        idle();
        tick();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 0;
        tick();
        // R1: everything free
        for (int i = 0; i < 8; i++) rd_both(i, 8'hFF, 8'hFF, "R1 reset");

        // R4 R5 R6 R7: the ten-step sequence on flag 5
        wr(1, 5, 8'h00); rd_both(5, 8'h00, 8'hFF, "R4 L0");
        wr(0, 5, 8'h00); rd_both(5, 8'h00, 8'hFF, "R5 R0");
        wr(1, 5, 8'h01); rd_both(5, 8'hFF, 8'h00, "R6 L1");
        wr(1, 5, 8'h00); rd_both(5, 8'hFF, 8'h00, "R5 L0");
        wr(0, 5, 8'h01); rd_both(5, 8'h00, 8'hFF, "R6 R1");
        wr(1, 5, 8'h01); rd_both(5, 8'hFF, 8'hFF, "R7 L1");
        wr(0, 5, 8'h00); rd_both(5, 8'hFF, 8'h00, "R4 R0");
        wr(0, 5, 8'h01); rd_both(5, 8'hFF, 8'hFF, "R7 R1");
        wr(1, 5, 8'h00); rd_both(5, 8'h00, 8'hFF, "R4 L0b");
        wr(1, 5, 8'h01); rd_both(5, 8'hFF, 8'hFF, "R7 L1b");

        // R10: same-cycle claims on free flag 2
        l_sel = 1; l_we = 1; l_addr = mk_addr(2); l_wdata = 8'h00;
        r_sel = 1; r_we = 1; r_addr = mk_addr(2); r_wdata = 8'h00;
        tick(); idle();
        rd_both(2, 8'h00, 8'hFF, "R10 tie");
        wr(1, 2, 8'h01); rd_both(2, 8'hFF, 8'h00, "R10 pending kept");
        wr(0, 2, 8'h01); rd_both(2, 8'hFF, 8'hFF, "R10 freed");

        // R7: withdrawal of a pending claim
        wr(1, 4, 8'h00); wr(0, 4, 8'h00); wr(0, 4, 8'h01);
        wr(1, 4, 8'h01); rd_both(4, 8'hFF, 8'hFF, "R7 withdraw");

        // R3: only bit 0 matters, and select gates the write
        wr(0, 6, 8'hFE); rd_both(6, 8'hFF, 8'h00, "R3 bit0 claim");
        wr(0, 6, 8'h01); rd_both(6, 8'hFF, 8'hFF, "R3 bit0 release");
        l_we = 1; l_addr = mk_addr(6); l_wdata = 8'h00;
        tick(); idle();
        rd_both(6, 8'hFF, 8'hFF, "R3 no select");

        // R2: high address bits differ, same flag
        l_sel = 1; l_we = 1; l_addr = 12'hFF8 | 12'd1; l_wdata = 8'h00; tick(); idle();
        rd_both(1, 8'h00, 8'hFF, "R2 alias");
        l_sel = 1; l_we = 1; l_addr = 12'h009; l_wdata = 8'h01; tick(); idle();
        rd_both(1, 8'hFF, 8'hFF, "R2 alias release");

        // R9: held read across a handoff by the other side on flag 3
        wr(0, 3, 8'h00); wr(1, 3, 8'h00);
        l_sel = 1; l_oe = 1; l_addr = mk_addr(3);
        tick();
        chk("R9 capture", l_rdata, 8'hFF);
        r_sel = 1; r_we = 1; r_addr = mk_addr(3); r_wdata = 8'h01;
        tick();
        r_sel = 0; r_we = 0;
        for (int k = 0; k < 3; k++) begin tick(); chk("R9 frozen", l_rdata, 8'hFF); end
        l_oe = 0; tick(); chk("R9 idle", l_rdata, 8'hFF);
        idle();
        rd_both(3, 8'h00, 8'hFF, "R9 fresh read");

        // R12: others untouched while flag 3 is held
        for (int i = 0; i < 8; i++)
            if (i != 3) rd_both(i, 8'hFF, 8'hFF, "R12 independent");

        // R11: claim persists over a long idle stretch
        for (int k = 0; k < 3000; k++) tick();
        rd_both(3, 8'h00, 8'hFF, "R11 no timeout");
        wr(0, 3, 8'h00); rd_both(3, 8'h00, 8'hFF, "R11 still blocked");

        // R8: readback spread checked on reads of an owned flag from each side
        wr(1, 3, 8'h01);
        rd_both(3, 8'hFF, 8'h00, "R8 spread");

        // R1: reset again clears held flags
        rst = 1; tick(); rst = 0; tick();
        rd_both(3, 8'hFF, 8'hFF, "R1 second reset");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule